// File: doc/BRIEF.md
# DDR2 Write Burst Sequencer

The sequencer accepts one write request at a time over a valid/ready handshake and converts it into DDR2 command traffic plus a stream of data beats for a downstream PHY. Each request names a bank, a row, a column, how many words it covers (1 to 8) and a byte-enable nibble for every beat. A per-bank table remembers which row is open. Depending on that table, the request goes through one of three paths: it may be written straight away, it may first need a row activation, or the old row may first need to be closed and the new row activated.

Every write is an eight-beat burst. Data begins CAS latency minus one cycles after the write command. Lanes the request does not enable, and beats past the requested word count, are masked. After a write the row is left open. Rows are closed by a row conflict or by a page-invalidate pulse, which precharges every bank at once. A width select chooses a 32-bit or 16-bit memory. In 16-bit mode the upper two lanes are always masked, and the column field is taken as a halfword address rather than a word address.

Top module: `ddr2_wr_seq`

## Requirements
- R1: A write command is issued to a bank only after an activate to that bank. A request to a bank with no open row issues activate (row on the address pins) and then write, with exactly tRCD cycles between them.
- R2: Command pins {cs_n, ras_n, cas_n, we_n} encode idle 0111, activate 0011, write 0100 and precharge 0010. During write, the address carries the column on its low bits with bit 10 low, and the bank pins carry the requested bank.
- R3: The first data beat is presented exactly CAS latency minus 1 cycles after the write command.
- R4: Every write produces exactly eight consecutive beats with dq_en_o high.
- R5: On beat b (b below the word count), dqm_o lane k is high exactly when byte-enable bit 4*b+k is low, and dq_o carries bits 32*b+31..32*b of the data on every enabled lane.
- R6: Beats whose index is at or above the word count have all four dqm_o bits high.
- R7: With the width select low (16-bit memory), dqm_o[3:2] are high on every beat.
- R8: A request that hits a bank's open row issues only a write, with no activate and no precharge, and the row stays open after the burst.
- R9: A request whose bank holds a different open row issues precharge to that bank (address bit 10 low), activate tRP cycles later, and write tRCD cycles after the activate.
- R10: A page-invalidate pulse, when any bank is open, causes exactly one precharge with address bit 10 high. Ready returns tRP cycles after it, and every bank then counts as closed. When no bank is open, no command is issued and ready returns two cycles after the pulse.
- R11: req_ready_o is low from the cycle after acceptance until the last beat, and high in the cycle that follows the last beat.
- R12: After reset the pins show the idle command, dqm_o is all high, dq_en_o is low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 3 | CAS latency, 2 to 7 |
| t_rp_i | input | 4 | Precharge-to-activate delay in cycles |
| t_rcd_i | input | 4 | Activate-to-write delay in cycles |
| wide_i | input | 1 | 1 = 32-bit memory, 0 = 16-bit memory |
| inval_i | input | 1 | Page-invalidate pulse |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_bank_i | input | 3 | Target bank |
| req_row_i | input | 14 | Target row |
| req_col_i | input | 10 | Start column |
| req_len_i | input | 4 | Word count, 1 to 8 |
| req_data_i | input | 256 | Eight 32-bit beat words, beat 0 in the low bits |
| req_be_i | input | 32 | Eight byte-enable nibbles, beat 0 in the low bits |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 3 | Bank address |
| addr_o | output | 14 | Row/column address |
| dq_o | output | 32 | Beat data |
| dqm_o | output | 4 | Per-lane mask, high = not written |
| dq_en_o | output | 1 | Beat valid |

## Verification
The checks assume that CAS latency is at least 2, that the timing and width inputs stay fixed from acceptance until ready returns, that the word count is between 1 and 8, and that invalidate is a single-cycle pulse. The bench changes configuration only while ready is high. It uses CAS latencies from 2 to 7 and delays of 1 to 4 cycles, and it issues invalidate only when the sequencer is idle. Under those conditions, the beat-latency and burst-length properties can use a plain cycle counter started by the write command.

// File: rtl/ddr2_wr_pkg.sv
`timescale 1ns/1ps
package ddr2_wr_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_TRP, ST_ACT, ST_TRCD,
    ST_WR, ST_BURST, ST_PALL, ST_TRPA
  } seq_state_e;
endpackage

// File: rtl/ddr2_bank_table.sv
`timescale 1ns/1ps
module ddr2_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BA_W-1:0]  look_ba_i,
  input  logic [ROW_W-1:0] look_row_i,
  output logic             open_o,
  output logic             hit_o,
  output logic             any_open_o,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             clr_i,
  input  logic [BA_W-1:0]  upd_ba_i,
  input  logic [ROW_W-1:0] act_row_i
);
  logic [NUM_BANKS-1:0] vld_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        row_q[g] <= '0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (act_i && upd_ba_i == BA_W'(g)) begin
        vld_q[g] <= 1'b1;
        row_q[g] <= act_row_i;
      end else if (pre_i && upd_ba_i == BA_W'(g)) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign open_o     = vld_q[look_ba_i];
  assign hit_o      = open_o && (row_q[look_ba_i] == look_row_i);
  assign any_open_o = |vld_q;
endmodule

// File: rtl/ddr2_beat_gen.sv
`timescale 1ns/1ps
module ddr2_beat_gen #(
  parameter int LANES     = 4,
  parameter int BURST_LEN = 8,
  localparam int IDX_W    = $clog2(BURST_LEN),
  localparam int LEN_W    = IDX_W + 1,
  localparam int DQ_W     = 8 * LANES
) (
  input  logic                       beat_on_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic                       wide_i,
  input  logic [BURST_LEN*DQ_W-1:0]  data_i,
  input  logic [BURST_LEN*LANES-1:0] be_i,
  output logic [DQ_W-1:0]            dq_o,
  output logic [LANES-1:0]           dqm_o
);
  logic [DQ_W-1:0]  word;
  logic [LANES-1:0] be;
  logic             live;

  assign word = data_i[idx_i*DQ_W +: DQ_W];
  assign be   = be_i[idx_i*LANES +: LANES];
  assign live = beat_on_i && ({1'b0, idx_i} < len_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit NARROW_OFF = (g >= LANES / 2);
    logic present;
    assign present        = wide_i || !NARROW_OFF;
    assign dqm_o[g]       = !(live && be[g] && present);
    assign dq_o[g*8 +: 8] = (beat_on_i && present) ? word[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ddr2_cmd_drv.sv
`timescale 1ns/1ps
module ddr2_cmd_drv import ddr2_wr_pkg::*; #(
  parameter int BA_W  = 3,
  parameter int ROW_W = 14,
  parameter int COL_W = 10
) (
  input  cmd_e             cmd_i,
  input  logic             all_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);
  always_comb begin
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_i;
    ba_o   = '0;
    addr_o = '0;
    unique case (cmd_i)
      CMD_ACT: begin
        ba_o   = ba_i;
        addr_o = row_i;
      end
      CMD_WR: begin
        ba_o                = ba_i;
        addr_o[COL_W-1:0]   = col_i;  // bit 10 stays low: no auto-precharge
      end
      CMD_PRE: begin
        ba_o       = all_i ? '0 : ba_i;
        addr_o[10] = all_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_wr_seq.sv
`timescale 1ns/1ps
module ddr2_wr_seq import ddr2_wr_pkg::*; #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int LANES     = 4,
  parameter int BURST_LEN = 8,
  parameter int TIM_W     = 4,
  parameter int CL_W      = 3,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int DQ_W     = 8 * LANES,
  localparam int IDX_W    = $clog2(BURST_LEN),
  localparam int LEN_W    = IDX_W + 1,
  localparam int DCNT_W   = CL_W + IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CL_W-1:0]            cas_lat_i,
  input  logic [TIM_W-1:0]           t_rp_i,
  input  logic [TIM_W-1:0]           t_rcd_i,
  input  logic                       wide_i,
  input  logic                       inval_i,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [BA_W-1:0]            req_bank_i,
  input  logic [ROW_W-1:0]           req_row_i,
  input  logic [COL_W-1:0]           req_col_i,
  input  logic [LEN_W-1:0]           req_len_i,
  input  logic [BURST_LEN*DQ_W-1:0]  req_data_i,
  input  logic [BURST_LEN*LANES-1:0] req_be_i,
  output logic                       cs_n_o,
  output logic                       ras_n_o,
  output logic                       cas_n_o,
  output logic                       we_n_o,
  output logic [BA_W-1:0]            ba_o,
  output logic [ROW_W-1:0]           addr_o,
  output logic [DQ_W-1:0]            dq_o,
  output logic [LANES-1:0]           dqm_o,
  output logic                       dq_en_o
);
  seq_state_e                 state_q;
  logic [TIM_W-1:0]           wcnt_q;
  logic [DCNT_W-1:0]          dcnt_q;
  logic                       inv_pend_q;
  logic [BA_W-1:0]            ba_q;
  logic [ROW_W-1:0]           row_q;
  logic [COL_W-1:0]           col_q;
  logic [LEN_W-1:0]           len_q;
  logic [BURST_LEN*DQ_W-1:0]  data_q;
  logic [BURST_LEN*LANES-1:0] be_q;

  logic tbl_open, tbl_hit, tbl_any;
  logic acc;
  logic [DCNT_W-1:0] wl, last_cnt;
  logic beat_on;
  cmd_e cmd;

  assign req_ready_o = (state_q == ST_IDLE) && !inv_pend_q;
  assign acc         = req_valid_i && req_ready_o;
  assign wl          = DCNT_W'(cas_lat_i) - DCNT_W'(1);
  assign last_cnt    = wl + DCNT_W'(BURST_LEN - 1);
  assign beat_on     = (state_q == ST_BURST) && (dcnt_q >= wl);
  assign dq_en_o     = beat_on;

  ddr2_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_ba_i  (req_bank_i),
    .look_row_i (req_row_i),
    .open_o     (tbl_open),
    .hit_o      (tbl_hit),
    .any_open_o (tbl_any),
    .act_i      (state_q == ST_ACT),
    .pre_i      (state_q == ST_PRE),
    .clr_i      (state_q == ST_PALL),
    .upd_ba_i   (ba_q),
    .act_row_i  (row_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inv_pend_q <= 1'b0;
    else         inv_pend_q <= inval_i || (inv_pend_q && state_q != ST_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ba_q   <= '0;
      row_q  <= '0;
      col_q  <= '0;
      len_q  <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (acc) begin
      ba_q   <= req_bank_i;
      row_q  <= req_row_i;
      col_q  <= req_col_i;
      len_q  <= req_len_i;
      data_q <= req_data_i;
      be_q   <= req_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (inv_pend_q) state_q <= tbl_any ? ST_PALL : ST_IDLE;
          else if (acc) begin
            if (tbl_hit)       state_q <= ST_WR;
            else if (tbl_open) state_q <= ST_PRE;
            else               state_q <= ST_ACT;
          end
        end
        ST_PRE, ST_PALL: begin
          if (t_rp_i <= TIM_W'(1)) state_q <= (state_q == ST_PRE) ? ST_ACT : ST_IDLE;
          else begin
            wcnt_q  <= t_rp_i - TIM_W'(1);
            state_q <= (state_q == ST_PRE) ? ST_TRP : ST_TRPA;
          end
        end
        ST_TRP, ST_TRPA: begin
          if (wcnt_q <= TIM_W'(1)) state_q <= (state_q == ST_TRP) ? ST_ACT : ST_IDLE;
          else wcnt_q <= wcnt_q - TIM_W'(1);
        end
        ST_ACT: begin
          if (t_rcd_i <= TIM_W'(1)) state_q <= ST_WR;
          else begin
            wcnt_q  <= t_rcd_i - TIM_W'(1);
            state_q <= ST_TRCD;
          end
        end
        ST_TRCD: begin
          if (wcnt_q <= TIM_W'(1)) state_q <= ST_WR;
          else wcnt_q <= wcnt_q - TIM_W'(1);
        end
        ST_WR: begin
          dcnt_q  <= DCNT_W'(1);  // counts cycles since the write command
          state_q <= ST_BURST;
        end
        ST_BURST: begin
          dcnt_q <= dcnt_q + DCNT_W'(1);
          if (dcnt_q == last_cnt) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE, ST_PALL: cmd = CMD_PRE;
      ST_ACT:          cmd = CMD_ACT;
      ST_WR:           cmd = CMD_WR;
      default:         cmd = CMD_NOP;
    endcase
  end

  ddr2_cmd_drv #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_cmd (
    .cmd_i   (cmd),
    .all_i   (state_q == ST_PALL),
    .ba_i    (ba_q),
    .row_i   (row_q),
    .col_i   (col_q),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  ddr2_beat_gen #(.LANES(LANES), .BURST_LEN(BURST_LEN)) u_beat (
    .beat_on_i (beat_on),
    .idx_i     (IDX_W'(dcnt_q - wl)),
    .len_i     (len_q),
    .wide_i    (wide_i),
    .data_i    (data_q),
    .be_i      (be_q),
    .dq_o      (dq_o),
    .dqm_o     (dqm_o)
  );
endmodule

// File: rtl/ddr2_wr_seq_chk.sv
`timescale 1ns/1ps
module ddr2_wr_seq_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int LANES     = 4,
  parameter int BURST_LEN = 8,
  parameter int CL_W      = 3,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CL_W-1:0]  cas_lat_i,
  input logic             wide_i,
  input logic             req_ready_o,
  input logic             cs_n_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [BA_W-1:0]  ba_o,
  input logic [ROW_W-1:0] addr_o,
  input logic [LANES-1:0] dqm_o,
  input logic             dq_en_o
);
  logic [3:0] pins;
  logic is_wr, is_act, is_pre;
  logic [NUM_BANKS-1:0] open_seen;
  logic [5:0] since_wr;
  logic [5:0] run_len;

  assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_wr  = pins == 4'b0100;
  assign is_act = pins == 4'b0011;
  assign is_pre = pins == 4'b0010;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_seen <= '0;
      since_wr  <= '0;
      run_len   <= '0;
    end else begin
      if (is_act)                 open_seen[ba_o] <= 1'b1;
      else if (is_pre && addr_o[10]) open_seen   <= '0;
      else if (is_pre)            open_seen[ba_o] <= 1'b0;
      if (is_wr)                  since_wr <= 6'd1;
      else if (since_wr != 6'h3f) since_wr <= since_wr + 6'd1;
      run_len <= dq_en_o ? run_len + 6'd1 : 6'd0;
    end
  end

  AST_WR_AFTER_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |-> open_seen[ba_o]);  // R1
  AST_WR_NO_AUTOPRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |-> !addr_o[10]);  // R2
  AST_WRITE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_en_o) |-> since_wr == 6'(cas_lat_i) - 6'd1);  // R3
  AST_BURST_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_en_o |-> run_len < 6'(BURST_LEN));  // R4
  AST_BURST_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_en_o) |-> run_len == 6'(BURST_LEN));  // R4
  AST_IDLE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_en_o |-> dqm_o == '1);  // R6
  AST_NARROW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_en_o && !wide_i) |-> dqm_o[LANES-1:LANES/2] == '1);  // R7
  AST_BUSY_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_en_o |-> !req_ready_o);  // R11
endmodule

bind ddr2_wr_seq ddr2_wr_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .LANES(LANES),
  .BURST_LEN(BURST_LEN), .CL_W(CL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cas_lat_i   (cas_lat_i),
  .wide_i      (wide_i),
  .req_ready_o (req_ready_o),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .dqm_o       (dqm_o),
  .dq_en_o     (dq_en_o)
);

// File: tb/ddr2_wr_seq_test.sv
`timescale 1ns/1ps
module ddr2_wr_seq_test;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_WR = 4'b0100, C_PRE = 4'b0010;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic [2:0]   cas_lat = 3'd3;
  logic [3:0]   t_rp = 4'd2, t_rcd = 4'd2;
  logic         wide = 1'b1, inval = 1'b0, req_valid = 1'b0, req_ready;
  logic [2:0]   req_bank = '0;
  logic [13:0]  req_row = '0;
  logic [9:0]   req_col = '0;
  logic [3:0]   req_len = 4'd1;
  logic [255:0] req_data = '0;
  logic [31:0]  req_be = '0;
  logic         cs_n, ras_n, cas_n, we_n, dq_en;
  logic [2:0]   ba;
  logic [13:0]  addr;
  logic [31:0]  dq;
  logic [3:0]   dqm;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ddr2_wr_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .cas_lat_i(cas_lat), .t_rp_i(t_rp), .t_rcd_i(t_rcd),
    .wide_i(wide), .inval_i(inval), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_len_i(req_len),
    .req_data_i(req_data), .req_be_i(req_be), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .dq_o(dq), .dqm_o(dqm),
    .dq_en_o(dq_en)
  );

  typedef struct packed {
    logic [2:0]  cl;
    logic [3:0]  trp;
    logic [3:0]  trcd;
    logic        wide;
    logic [2:0]  ba;
    logic [13:0] row;
    logic [9:0]  col;
    logic [3:0]  len;
    logic [31:0] be;
    logic [1:0]  kind;  // 0 closed, 1 hit, 2 miss
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 4'd2, 4'd2, 1'b1, 3'd1, 14'd5,     10'd8,    4'd8, 32'hFFFFFFFF, 2'd0},
    '{3'd3, 4'd2, 4'd2, 1'b1, 3'd1, 14'd5,     10'd16,   4'd3, 32'h00000F31, 2'd1},
    '{3'd4, 4'd2, 4'd3, 1'b1, 3'd1, 14'd9,     10'd0,    4'd8, 32'hC3C3C3C3, 2'd2},
    '{3'd6, 4'd3, 4'd4, 1'b1, 3'd4, 14'd100,   10'd5,    4'd1, 32'h00000008, 2'd0},
    '{3'd3, 4'd2, 4'd2, 1'b0, 3'd4, 14'd100,   10'd32,   4'd8, 32'hFFFFFFFF, 2'd1},
    '{3'd2, 4'd1, 4'd1, 1'b1, 3'd1, 14'd9,     10'd40,   4'd5, 32'h000A5F3C, 2'd1},
    '{3'd7, 4'd4, 4'd3, 1'b1, 3'd7, 14'd16383, 10'd1023, 4'd8, 32'h12345678, 2'd0},
    '{3'd3, 4'd1, 4'd1, 1'b0, 3'd4, 14'd7,     10'd2,    4'd6, 32'h00F3C5A6, 2'd2}
  };

  function automatic logic [31:0] gen(input int id, input int b);
    return {8'(id), 8'(b), 16'hC35A ^ 16'(id * 37 + b * 11)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input int id, input vec_t v);
    int cc[4]; logic [3:0] ck[4]; logic [13:0] ca[4]; logic [2:0] cb[4];
    int bc[16]; logic [31:0] bd[16]; logic [3:0] bm[16];
    int ncmd = 0, nbeat = 0, rdy_c = 0, nexp, w;
    @(negedge clk);
    cas_lat = v.cl; t_rp = v.trp; t_rcd = v.trcd; wide = v.wide;
    req_bank = v.ba; req_row = v.row; req_col = v.col; req_len = v.len; req_be = v.be;
    for (int b = 0; b < 8; b++) req_data[b*32 +: 32] = gen(id, b);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R11 ready before request", 64'(req_ready), 64'd1);
    @(posedge clk);
    for (int k = 1; k <= 120 && rdy_c == 0; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP && ncmd < 4) begin
        cc[ncmd] = k; ck[ncmd] = {cs_n, ras_n, cas_n, we_n}; ca[ncmd] = addr; cb[ncmd] = ba;
        ncmd++;
      end
      if (dq_en && nbeat < 16) begin
        bc[nbeat] = k; bd[nbeat] = dq; bm[nbeat] = dqm; nbeat++;
      end
      if (req_ready) rdy_c = k;
    end
    nexp = (v.kind == 2'd1) ? 1 : (v.kind == 2'd0) ? 2 : 3;
    chk(ncmd == nexp, "R1 R8 R9 command count", 64'(ncmd), 64'(nexp));
    if (ncmd == nexp) begin
      w = nexp - 1;
      chk(cc[0] == 1, "R8 first command cycle", 64'(cc[0]), 64'd1);
      if (v.kind == 2'd2) begin
        chk(ck[0] == C_PRE && !ca[0][10] && cb[0] == v.ba, "R9 precharge of conflicting row",
            {ck[0], ca[0], cb[0]}, {C_PRE, 14'd0, v.ba});
        chk(cc[1] - cc[0] == int'(v.trp), "R9 precharge to activate gap", 64'(cc[1] - cc[0]), 64'(v.trp));
      end
      if (v.kind != 2'd1) begin
        chk(ck[w-1] == C_ACT && ca[w-1] == v.row && cb[w-1] == v.ba, "R1 activate row",
            {ck[w-1], ca[w-1], cb[w-1]}, {C_ACT, v.row, v.ba});
        chk(cc[w] - cc[w-1] == int'(v.trcd), "R1 activate to write gap", 64'(cc[w] - cc[w-1]), 64'(v.trcd));
      end
      chk(ck[w] == C_WR && ca[w] == {4'b0000, v.col} && cb[w] == v.ba, "R2 write command",
          {ck[w], ca[w], cb[w]}, {C_WR, 4'b0000, v.col, v.ba});
      if (nbeat > 0)
        chk(bc[0] - cc[w] == int'(v.cl) - 1, "R3 write latency", 64'(bc[0] - cc[w]), 64'(int'(v.cl) - 1));
    end
    chk(nbeat == 8, "R4 beat count", 64'(nbeat), 64'd8);
    if (nbeat == 8) begin
      chk(bc[7] - bc[0] == 7, "R4 beats contiguous", 64'(bc[7] - bc[0]), 64'd7);
      chk(rdy_c == bc[7] + 1, "R11 ready after last beat", 64'(rdy_c), 64'(bc[7] + 1));
      for (int b = 0; b < 8; b++) begin
        logic [3:0] em; logic [31:0] lm;
        em = (b >= int'(v.len)) ? 4'hF : ~v.be[b*4 +: 4];
        if (!v.wide) em = em | 4'hC;
        lm = {{8{~em[3]}}, {8{~em[2]}}, {8{~em[1]}}, {8{~em[0]}}};
        if (b >= int'(v.len)) chk(bm[b] == em, "R6 trailing beat mask", 64'(bm[b]), 64'(em));
        else if (!v.wide)     chk(bm[b] == em, "R7 narrow lane mask", 64'(bm[b]), 64'(em));
        else                  chk(bm[b] == em, "R5 lane mask", 64'(bm[b]), 64'(em));
        chk((bd[b] & lm) == (gen(id, b) & lm), "R5 beat data", 64'(bd[b] & lm), 64'(gen(id, b) & lm));
      end
    end
  endtask

  task automatic run_inval(input logic [3:0] trp, input bit any_open);
    int npre = 0, pre_c = 0, rdy_c = 0; logic a10 = 1'b0;
    @(negedge clk);
    t_rp = trp; inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after invalidate", 64'(req_ready), 64'd0);
    for (int k = 1; k <= 30; k++) begin
      if (k > 1) @(negedge clk);
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP) begin
        if ({cs_n, ras_n, cas_n, we_n} == C_PRE) begin npre++; pre_c = k; a10 = addr[10]; end
        else npre += 100;
      end
      if (req_ready && rdy_c == 0) rdy_c = k;
    end
    if (any_open) begin
      chk(npre == 1, "R10 single precharge-all", 64'(npre), 64'd1);
      chk(a10 == 1'b1, "R10 precharge-all A10", 64'(a10), 64'd1);
      chk(rdy_c == pre_c + int'(trp), "R10 ready after tRP", 64'(rdy_c), 64'(pre_c + int'(trp)));
    end else begin
      chk(npre == 0, "R10 no command when none open", 64'(npre), 64'd0);
      chk(rdy_c == 2, "R10 ready returns", 64'(rdy_c), 64'd2);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R12 idle command in reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'(C_NOP));
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);
    chk(dqm == 4'hF && dq_en == 1'b0, "R12 mask and beat enable after reset", {dqm, dq_en}, {4'hF, 1'b0});
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R12 idle command after reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'(C_NOP));

    for (int i = 0; i < NV; i++) run_req(i, VECS[i]);

    // banks 1, 4, 7 open: invalidate closes all
    run_inval(4'd3, 1'b1);
    // R10 row formerly open now needs a fresh activate, no precharge
    run_req(8, '{3'd3, 4'd2, 4'd2, 1'b1, 3'd1, 14'd9, 10'd24, 4'd8, 32'h5A5A5A5A, 2'd0});
    run_inval(4'd2, 1'b1);
    run_inval(4'd2, 1'b0);
    // R8 open row survives: same row hit after a write
    run_req(9, '{3'd5, 4'd2, 4'd2, 1'b1, 3'd2, 14'd77, 10'd3, 4'd2, 32'h000000F9, 2'd0});
    run_req(10, '{3'd5, 4'd2, 4'd2, 1'b1, 3'd2, 14'd77, 10'd11, 4'd7, 32'h0FEDCBA9, 2'd1});

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule